// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block decides the ordering of two unsigned binary words and reports it on three lines: one for "first operand greater", one for "operands equal", one for "first operand less". It is built from identical 4-bit slices. Each slice compares its own nibbles. When those nibbles differ, the slice reports its own result. When they are equal, the slice passes on the verdict of the next less significant slice. That verdict arrives on three cascade lines.

A parameterised wrapper chains the slices from the least significant nibble upward, so the default build compares 8 bits. The wrapper keeps the cascade lines of the bottom slice as ports. A user can therefore extend the chain with further instances. A standalone user ties those lines to the neutral verdict: greater low, equal high, less low. The logic is purely combinational: there is no clock, no state and no pipeline stage.

Top module: `magcmp_chain`

## Requirements
- R1: When exactly one of the three cascade inputs is high, exactly one of the three outputs is high, for every operand pair.
- R2: When `a_val` is greater than `b_val` as an unsigned number, `cmp_gt_o` is 1 and `cmp_eq_o` and `cmp_lt_o` are 0, whatever the cascade inputs carry.
- R3: When `a_val` is less than `b_val` as an unsigned number, `cmp_lt_o` is 1 and `cmp_gt_o` and `cmp_eq_o` are 0, whatever the cascade inputs carry.
- R4: When `a_val` equals `b_val`, each output copies its cascade input: `cmp_gt_o` copies `casc_gt_i`, `cmp_eq_o` copies `casc_eq_i`, and `cmp_lt_o` copies `casc_lt_i`. This holds for all eight cascade patterns, including patterns that are not one-hot.
- R5: The verdict is set by the most significant bit position where the operands differ. Lower bits never override it, even across a 4-bit slice boundary. For example, 8'h80 against 8'h7F gives greater, and 8'h0F against 8'h10 gives less.
- R6: With neutral cascade inputs (greater 0, equal 1, less 0), comparing 8'h06 with 8'h03 gives greater=1, equal=0, less=0.
- R7: The outputs are a pure function of the present inputs. A new input pattern gives its result in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_val | input | STAGE_W*STAGES (8) | First unsigned operand |
| b_val | input | STAGE_W*STAGES (8) | Second unsigned operand |
| casc_gt_i | input | 1 | Verdict "greater" from a less significant comparator |
| casc_eq_i | input | 1 | Verdict "equal" from a less significant comparator |
| casc_lt_i | input | 1 | Verdict "less" from a less significant comparator |
| cmp_gt_o | output | 1 | a_val greater than b_val |
| cmp_eq_o | output | 1 | a_val equal to b_val (after cascade) |
| cmp_lt_o | output | 1 | a_val less than b_val |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the ports. The bench drives each new operand pair and cascade pattern just after a rising edge of its clock. It samples the three outputs at the following falling edge, half a period later, so settled values are always read. The sweep covers all 65,536 operand pairs with the neutral cascade pattern. It also pairs every equal operand pair, and a set of unequal pairs, with all eight cascade patterns. Each sample is compared against a verdict computed with the language's own relational operators.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    // Three-line ordering verdict carried between slices
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // Verdict that a chain's bottom slice expects on its cascade lines
    localparam rel_t REL_NEUTRAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

    // Select the local verdict unless the local operands tie
    function automatic rel_t rel_resolve(rel_t local_r, rel_t lower_r);
        rel_t res;
        if (local_r.eq) res = lower_r;
        else            res = local_r;
        return res;
    endfunction

endpackage

// File: rtl/magcmp_bit_eq.sv
module magcmp_bit_eq #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] same_o
);
    // One XNOR per bit position
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign same_o[g] = ~(a_i[g] ^ b_i[g]);
    end
endmodule

// File: rtl/magcmp_local.sv
module magcmp_local
    import magcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] same_i,
    output rel_t         rel_o
);
    logic tie;
    logic a_bit_at_top_diff;

    // Ascending scan: a later (higher) differing position overwrites,
    // so the value left is the operand-a bit at the top differing position.
    always_comb begin
        a_bit_at_top_diff = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!same_i[i]) a_bit_at_top_diff = a_i[i];
        end
    end

    assign tie      = &same_i;
    assign rel_o.eq = tie;
    assign rel_o.gt = ~tie &  a_bit_at_top_diff;
    assign rel_o.lt = ~tie & ~a_bit_at_top_diff;
endmodule

// File: rtl/magcmp_stage.sv
module magcmp_stage
    import magcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  rel_t         lower_i,
    output rel_t         rel_o
);
    logic [W-1:0] same;
    rel_t         local_rel;

    magcmp_bit_eq #(.W(W)) u_eq (
        .a_i    (a_i),
        .b_i    (b_i),
        .same_o (same)
    );

    magcmp_local #(.W(W)) u_local (
        .a_i    (a_i),
        .same_i (same),
        .rel_o  (local_rel)
    );

    assign rel_o = rel_resolve(local_rel, lower_i);
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic [STAGE_W*STAGES-1:0] a_val,
    input  logic [STAGE_W*STAGES-1:0] b_val,
    input  logic                      casc_gt_i,
    input  logic                      casc_eq_i,
    input  logic                      casc_lt_i,
    output logic                      cmp_gt_o,
    output logic                      cmp_eq_o,
    output logic                      cmp_lt_o
);
    localparam int W = STAGE_W * STAGES;

    // link[0] enters the least significant slice, link[STAGES] leaves the top
    rel_t link [STAGES+1];

    assign link[0] = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        magcmp_stage #(.W(STAGE_W)) u_stage (
            .a_i     (a_val[s*STAGE_W +: STAGE_W]),
            .b_i     (b_val[s*STAGE_W +: STAGE_W]),
            .lower_i (link[s]),
            .rel_o   (link[s+1])
        );
    end

    assign cmp_gt_o = link[STAGES].gt;
    assign cmp_eq_o = link[STAGES].eq;
    assign cmp_lt_o = link[STAGES].lt;
endmodule

// File: rtl/magcmp_chain_chk.sv
module magcmp_chain_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_val,
    input logic [W-1:0] b_val,
    input logic         casc_gt_i,
    input logic         casc_eq_i,
    input logic         casc_lt_i,
    input logic         cmp_gt_o,
    input logic         cmp_eq_o,
    input logic         cmp_lt_o
);
    always_comb begin
        if (!$isunknown({a_val, b_val, casc_gt_i, casc_eq_i, casc_lt_i})) begin
            // R1
            if ($countones({casc_gt_i, casc_eq_i, casc_lt_i}) == 1)
                a_r1_one_hot: assert ($countones({cmp_gt_o, cmp_eq_o, cmp_lt_o}) == 1);
            // R2
            if (a_val > b_val)
                a_r2_greater: assert (cmp_gt_o && !cmp_eq_o && !cmp_lt_o);
            // R3
            if (a_val < b_val)
                a_r3_less: assert (cmp_lt_o && !cmp_eq_o && !cmp_gt_o);
            // R4
            if (a_val == b_val)
                a_r4_copy: assert ({cmp_gt_o, cmp_eq_o, cmp_lt_o} ==
                                   {casc_gt_i, casc_eq_i, casc_lt_i});
        end
    end
endmodule

bind magcmp_chain magcmp_chain_chk #(.W(STAGE_W*STAGES)) u_chk (
    .a_val     (a_val),
    .b_val     (b_val),
    .casc_gt_i (casc_gt_i),
    .casc_eq_i (casc_eq_i),
    .casc_lt_i (casc_lt_i),
    .cmp_gt_o  (cmp_gt_o),
    .cmp_eq_o  (cmp_eq_o),
    .cmp_lt_o  (cmp_lt_o)
);

// File: tb/magcmp_chain_tb.sv
`timescale 1ns/1ps
module magcmp_chain_tb;
    localparam int W = 8;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_val, b_val;
    logic casc_gt_i, casc_eq_i, casc_lt_i;
    logic cmp_gt_o, cmp_eq_o, cmp_lt_o;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    magcmp_chain #(.STAGE_W(4), .STAGES(2)) u_dut (
        .a_val     (a_val),
        .b_val     (b_val),
        .casc_gt_i (casc_gt_i),
        .casc_eq_i (casc_eq_i),
        .casc_lt_i (casc_lt_i),
        .cmp_gt_o  (cmp_gt_o),
        .cmp_eq_o  (cmp_eq_o),
        .cmp_lt_o  (cmp_lt_o)
    );

    // Drive after a rising edge, sample at the next falling edge
    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [2:0] casc, input string req);
        logic [2:0] exp_v, act;
        @(posedge clk);
        #1;
        a_val = a; b_val = b;
        {casc_gt_i, casc_eq_i, casc_lt_i} = casc;
        @(negedge clk);
        if (a > b)      exp_v = 3'b100;
        else if (a < b) exp_v = 3'b001;
        else            exp_v = casc;
        act = {cmp_gt_o, cmp_eq_o, cmp_lt_o};
        n_total++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h casc=%b actual=%b expected=%b",
                     req, a, b, casc, act, exp_v);
        end
    endtask

    initial begin
        a_val = '0; b_val = '0;
        {casc_gt_i, casc_eq_i, casc_lt_i} = 3'b010;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Initial state: equal operands with neutral cascade -> equal only (R4)
        apply_check(8'h00, 8'h00, 3'b010, "R4_init");
        // R6: worked example
        apply_check(8'h06, 8'h03, 3'b010, "R6");
        // R5: slice boundary cases
        apply_check(8'h80, 8'h7F, 3'b010, "R5_hi");
        apply_check(8'h0F, 8'h10, 3'b010, "R5_lo");
        apply_check(8'h1F, 8'h10, 3'b001, "R5_cascade_ignored");
        // R1 R2 R3 R7: exhaustive sweep, neutral cascade, fresh pattern every cycle
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply_check(W'(a), W'(b), 3'b010, "R1_R2_R3_R7");
        // R4: every equal pair with all eight cascade patterns
        for (int a = 0; a < 256; a++)
            for (int c = 0; c < 8; c++)
                apply_check(W'(a), W'(a), 3'(c), "R4");
        // R2 R3: unequal pairs with every cascade pattern
        for (int a = 0; a < 256; a += 17)
            for (int c = 0; c < 8; c++) begin
                apply_check(W'(a), W'(a ^ 1), 3'(c), "R2_R3_cascade");
                apply_check(W'(a), W'(a ^ 8'h10), 3'(c), "R2_R3_cascade_hi");
            end
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            done = 1'b1;
        end
    end

    initial begin
        wait (done);
        #10;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule